// File: doc/BRIEF.md
# CAN Node Halt Controller

This block decides when a CAN node withdraws from bus traffic and when it may return. Software raises a halt request; the block looks at what the protocol engine is doing. If the engine is idle or in intermission, or the node is bus-off, the node leaves the bus in the next cycle. If a frame is being sent or received, the block lets that frame run to its end-of-frame strobe and then halts. While halted, the bus-participation enable is low, so the frame engine neither sends nor stores anything. A status bit and a single-cycle interrupt pulse report the entry into halt.

After software drops the request, the node does not rejoin at once. It waits for a run of consecutive recessive bits, 11 by default, and any dominant bit restarts that run. The block also times the automatic bus-off recovery: a number of 11-bit recessive groups, 128 by default. It signals the error logic with a one-cycle clear pulse when the count is done. A halt requested during bus-off stops that recovery. Recovery restarts from zero only after the request is withdrawn and the node has rejoined.

Top module: `can_halt_ctrl`

## Requirements
- R1: After synchronous reset the outputs are bus_en_o=1, halted_o=0, halt_irq_o=0 and busoff_clear_o=0, which is normal operation.
- R2: A request seen while eng_state_i is idle (0) or intermission (1), or while bus_off_i=1, sets halted_o=1 and bus_en_o=0 in the next cycle.
- R3: A request seen while eng_state_i is transmit (2) or receive (3) keeps bus_en_o=1 and halted_o=0 until eof_i or bus_off_i is sampled, and halted_o rises in the following cycle. If the request is withdrawn before that, the node stays in normal operation and gives no interrupt.
- R4: While halted and the request stays set, halted_o stays 1 and bus_en_o stays 0 whatever the bus bits and end-of-frame strobes do. bus_en_o and halted_o are never both 1.
- R5: halt_irq_o is a single-cycle pulse issued exactly when halted_o rises.
- R6: After the request is cleared, halted_o stays 1 until REJOIN_BITS consecutive recessive bit strobes have been sampled (bit_tick_i=1 with bit_rec_i=1). In the cycle after the last of them, bus_en_o=1 and halted_o=0.
- R7: A bit strobe with bit_rec_i=0 during the rejoin wait restarts the recessive run from zero.
- R8: A request raised again during the rejoin wait returns the node to the held halt. halted_o stays 1 and no new interrupt is issued.
- R9: While bus_off_i=1 in normal operation, each run of REJOIN_BITS consecutive recessive strobes counts one group, and a dominant strobe restarts only the partial group. busoff_clear_o pulses for one cycle in the cycle after the strobe that completes group RECOVERY_GROUPS.
- R10: While a halt requested during bus-off is in force, busoff_clear_o stays 0. Recovery counting restarts from zero only once the node has rejoined.
- R11: eng_state_i encodes 0 idle, 1 intermission, 2 transmit, 3 receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Software halt request, 1 = halt |
| eng_state_i | input | 2 | Protocol engine state (R11 encoding) |
| eof_i | input | 1 | One-cycle end-of-frame strobe |
| bus_off_i | input | 1 | Node is bus-off |
| bit_tick_i | input | 1 | One-cycle strobe per sampled bus bit |
| bit_rec_i | input | 1 | Value of the sampled bit, 1 = recessive |
| bus_en_o | output | 1 | Node may take part in bus traffic |
| halted_o | output | 1 | Halt status |
| halt_irq_o | output | 1 | One-cycle pulse on halt entry |
| busoff_clear_o | output | 1 | One-cycle pulse ending bus-off recovery |

## Verification
The bench builds the block with REJOIN_BITS=11 and RECOVERY_GROUPS=3. The rejoin window keeps its true length, so the off-by-one edges around the eleventh recessive bit are checked exactly. With only three recovery groups, a complete bus-off recovery fits in a few hundred cycles. That makes it possible to compare a completed recovery against one that a halt has suppressed, and to confirm the restart from zero after rejoin.

// File: rtl/can_halt_pkg.sv
package can_halt_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_IFS  = 2'd1,
    ENG_TX   = 2'd2,
    ENG_RX   = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    HS_RUN    = 2'd0,
    HS_DRAIN  = 2'd1,
    HS_HALT   = 2'd2,
    HS_REJOIN = 2'd3
  } halt_st_e;

endpackage

// File: rtl/hm_bit_run.sv
// Counts consecutive qualifying strobes; a miss restarts the run.
module hm_bit_run #(
  parameter int LEN = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic hit,
  output logic done
);
  localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  assign done = !clr && tick && hit && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (!hit || cnt_q == LAST) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hm_halt_fsm.sv
module hm_halt_fsm
  import can_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req_i,
  input  logic [1:0] eng_state_i,
  input  logic       eof_i,
  input  logic       bus_off_i,
  input  logic       rejoin_done_i,
  output halt_st_e   st_q,
  output logic       bus_en_q,
  output logic       halted_q,
  output logic       irq_q
);
  halt_st_e st_d;
  logic     bus_quiet;

  assign bus_quiet = (eng_state_i == ENG_IDLE) || (eng_state_i == ENG_IFS);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN:    if (halt_req_i) st_d = (bus_quiet || bus_off_i) ? HS_HALT : HS_DRAIN;
      HS_DRAIN:  if (!halt_req_i) st_d = HS_RUN;
                 else if (eof_i || bus_off_i) st_d = HS_HALT;
      HS_HALT:   if (!halt_req_i) st_d = HS_REJOIN;
      HS_REJOIN: if (halt_req_i) st_d = HS_HALT;
                 else if (rejoin_done_i) st_d = HS_RUN;
      default:   st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= HS_RUN;
      bus_en_q <= 1'b1;
      halted_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      bus_en_q <= (st_d == HS_RUN) || (st_d == HS_DRAIN);
      halted_q <= (st_d == HS_HALT) || (st_d == HS_REJOIN);
      irq_q    <= (st_d == HS_HALT) && ((st_q == HS_RUN) || (st_q == HS_DRAIN));
    end
  end
endmodule

// File: rtl/can_halt_ctrl.sv
module can_halt_ctrl
  import can_halt_pkg::*;
#(
  parameter int REJOIN_BITS     = 11,
  parameter int RECOVERY_GROUPS = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halt_req_i,
  input  logic [1:0] eng_state_i,
  input  logic       eof_i,
  input  logic       bus_off_i,
  input  logic       bit_tick_i,
  input  logic       bit_rec_i,
  output logic       bus_en_o,
  output logic       halted_o,
  output logic       halt_irq_o,
  output logic       busoff_clear_o
);
  halt_st_e st_q;
  logic     rejoin_done, rejoin_clr;
  logic     rec_clr, grp_done, rec_done;

  assign rejoin_clr = !((st_q == HS_REJOIN) && !halt_req_i);
  assign rec_clr    = !(bus_off_i && (st_q == HS_RUN));

  hm_bit_run #(.LEN(REJOIN_BITS)) u_rejoin_run (
    .clk(clk), .rst(rst), .clr(rejoin_clr),
    .tick(bit_tick_i), .hit(bit_rec_i), .done(rejoin_done)
  );

  hm_bit_run #(.LEN(REJOIN_BITS)) u_group_run (
    .clk(clk), .rst(rst), .clr(rec_clr),
    .tick(bit_tick_i), .hit(bit_rec_i), .done(grp_done)
  );

  // Each completed group is one "hit" strobe for the group counter.
  hm_bit_run #(.LEN(RECOVERY_GROUPS)) u_group_cnt (
    .clk(clk), .rst(rst), .clr(rec_clr),
    .tick(grp_done), .hit(1'b1), .done(rec_done)
  );

  hm_halt_fsm u_fsm (
    .clk(clk), .rst(rst),
    .halt_req_i(halt_req_i), .eng_state_i(eng_state_i),
    .eof_i(eof_i), .bus_off_i(bus_off_i),
    .rejoin_done_i(rejoin_done),
    .st_q(st_q), .bus_en_q(bus_en_o), .halted_q(halted_o), .irq_q(halt_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) busoff_clear_o <= 1'b0;
    else     busoff_clear_o <= rec_done;
  end
endmodule

// File: rtl/can_halt_ctrl_chk.sv
module can_halt_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic halt_req_i,
  input logic bus_off_i,
  input logic bit_tick_i,
  input logic bit_rec_i,
  input logic bus_en_o,
  input logic halted_o,
  input logic halt_irq_o,
  input logic busoff_clear_o
);
  assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(bus_en_o && halted_o));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (halted_o && halt_req_i) |=> halted_o);
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (rst)
    halt_irq_o |=> !halt_irq_o);
  assert_irq_on_entry_R5: assert property (@(posedge clk) disable iff (rst)
    halt_irq_o |-> $rose(halted_o));
  assert_entry_irq_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(halted_o) |-> halt_irq_o);
  assert_rejoin_bit_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_en_o) |-> $past(bit_tick_i && bit_rec_i && !halt_req_i));
  assert_clear_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    busoff_clear_o |=> !busoff_clear_o);
  assert_clear_running_R10: assert property (@(posedge clk) disable iff (rst)
    busoff_clear_o |-> $past(bus_en_o && !halted_o && bus_off_i));
endmodule

bind can_halt_ctrl can_halt_ctrl_chk u_chk (.*);

// File: tb/can_halt_ctrl_tb.sv
module can_halt_ctrl_tb;
  localparam int RB = 11;
  localparam int RG = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, eof = 0, bus_off = 0, tick = 0, rec = 0;
  logic [1:0] eng = 2'd0;
  logic bus_en, halted, irq, bclr;

  int tests = 0, fails = 0;

  can_halt_ctrl #(.REJOIN_BITS(RB), .RECOVERY_GROUPS(RG)) u_dut (
    .clk(clk), .rst(rst), .halt_req_i(halt_req), .eng_state_i(eng),
    .eof_i(eof), .bus_off_i(bus_off), .bit_tick_i(tick), .bit_rec_i(rec),
    .bus_en_o(bus_en), .halted_o(halted), .halt_irq_o(irq), .busoff_clear_o(bclr)
  );

  always #5 clk = ~clk;

  // Behavioural reference: 0 running, 1 finishing frame, 2 held, 3 waiting to rejoin
  int m_st, m_run, m_brun, m_bgrp;
  logic m_en, m_halt, m_irq, m_clr;

  always @(posedge clk) begin
    int ns;
    if (rst) begin
      m_st = 0; m_run = 0; m_brun = 0; m_bgrp = 0;
      m_en = 1; m_halt = 0; m_irq = 0; m_clr = 0;
    end else begin
      ns = m_st; m_clr = 0;
      if (m_st == 0 && bus_off) begin
        if (tick && rec) begin
          m_brun++;
          if (m_brun == RB) begin
            m_brun = 0; m_bgrp++;
            if (m_bgrp == RG) begin m_bgrp = 0; m_clr = 1; end
          end
        end else if (tick) m_brun = 0;
      end else begin m_brun = 0; m_bgrp = 0; end
      case (m_st)
        0: if (halt_req) ns = (bus_off || eng < 2) ? 2 : 1;
        1: if (!halt_req) ns = 0; else if (eof || bus_off) ns = 2;
        2: if (!halt_req) ns = 3;
        default: begin
          if (halt_req) begin ns = 2; m_run = 0; end
          else if (tick && rec) begin
            m_run++;
            if (m_run == RB) begin m_run = 0; ns = 0; end
          end else if (tick) m_run = 0;
        end
      endcase
      if (ns != 3) m_run = 0;
      m_irq = (ns == 2) && (m_st < 2);
      m_halt = (ns >= 2);
      m_en = (ns < 2);
      m_st = ns;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R6 bus_en vs model", 32'(bus_en), 32'(m_en));
    chk("R4 halted vs model", 32'(halted), 32'(m_halt));
    chk("R5 irq vs model", 32'(irq), 32'(m_irq));
    chk("R9 clear vs model", 32'(bclr), 32'(m_clr));
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic bit_in(logic r);
    tick = 1; rec = r; cyc(); tick = 0; rec = 0; cyc();
  endtask

  task automatic rec_bits(int n);
    for (int i = 0; i < n; i++) bit_in(1'b1);
  endtask

  int irq_seen;

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    chk("R1 reset bus_en", 32'(bus_en), 1);
    chk("R1 reset halted", 32'(halted), 0);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset clear", 32'(bclr), 0);

    // R2 / R11: idle request halts at once
    eng = 2'd0; halt_req = 1; cyc();
    chk("R2 idle halted", 32'(halted), 1);
    chk("R2 idle bus_en", 32'(bus_en), 0);
    chk("R5 irq pulse", 32'(irq), 1);
    cyc();
    chk("R5 irq single", 32'(irq), 0);
    // R4: bus activity ignored while held
    eng = 2'd3; eof = 1; cyc(); eof = 0;
    rec_bits(RB + 2); bit_in(1'b0);
    chk("R4 still halted", 32'(halted), 1);
    chk("R4 still off bus", 32'(bus_en), 0);

    // R6 / R7: rejoin wait
    eng = 2'd0; halt_req = 0; cyc();
    rec_bits(RB - 1);
    chk("R6 ten bits not enough", 32'(halted), 1);
    bit_in(1'b0);
    rec_bits(RB - 1);
    chk("R7 dominant restarted run", 32'(bus_en), 0);
    tick = 1; rec = 1; cyc(); tick = 0; rec = 0;
    chk("R6 rejoined bus_en", 32'(bus_en), 1);
    chk("R6 rejoined halted", 32'(halted), 0);
    cyc();

    // R11 intermission halts at once; R8 re-request during rejoin
    eng = 2'd1; halt_req = 1; cyc();
    chk("R11 intermission halts", 32'(halted), 1);
    cyc(); halt_req = 0; cyc();
    rec_bits(5);
    irq_seen = 0;
    halt_req = 1; cyc();
    if (irq) irq_seen = 1;
    cyc(); if (irq) irq_seen = 1;
    chk("R8 back to held", 32'(halted), 1);
    chk("R8 no new irq", 32'(irq_seen), 0);
    halt_req = 0; cyc();
    rec_bits(RB);
    chk("R6 rejoin after R8", 32'(bus_en), 1);

    // R3 transmit: drain until end of frame
    eng = 2'd2; halt_req = 1;
    repeat (4) cyc();
    chk("R3 tx still on bus", 32'(bus_en), 1);
    chk("R3 tx not halted", 32'(halted), 0);
    eof = 1; cyc(); eof = 0;
    chk("R3 halt after eof", 32'(halted), 1);
    chk("R3 irq after eof", 32'(irq), 1);
    halt_req = 0; eng = 2'd0; cyc();
    rec_bits(RB);

    // R3 receive: request withdrawn before end of frame
    eng = 2'd3; halt_req = 1; repeat (3) cyc();
    halt_req = 0; cyc();
    eof = 1; cyc(); eof = 0; cyc();
    chk("R3 withdrawn stays running", 32'(bus_en), 1);
    chk("R3 withdrawn no halt", 32'(halted), 0);
    eng = 2'd0;

    // R9 bus-off recovery with a dominant bit in mid-group
    bus_off = 1; cyc();
    rec_bits(RB + 4); bit_in(1'b0);
    rec_bits(RB * (RG - 1) - 1);
    chk("R9 no clear one bit early", 32'(bclr), 0);
    tick = 1; rec = 1; cyc(); tick = 0; rec = 0;
    chk("R9 clear pulse", 32'(bclr), 1);
    cyc();
    chk("R9 clear one cycle", 32'(bclr), 0);
    bus_off = 0; cyc();

    // R10 halt during bus-off suppresses recovery
    bus_off = 1; eng = 2'd2; halt_req = 1; cyc();
    chk("R2 bus-off halts at once", 32'(halted), 1);
    rec_bits(RB * RG + 3);
    chk("R10 no recovery while held", 32'(bclr), 0);
    halt_req = 0; eng = 2'd0; cyc();
    rec_bits(RB);
    chk("R10 rejoined", 32'(bus_en), 1);
    rec_bits(RB * RG - 1);
    chk("R10 count restarted", 32'(bclr), 0);
    tick = 1; rec = 1; cyc(); tick = 0; rec = 0;
    chk("R10 recovery after rejoin", 32'(bclr), 1);
    bus_off = 0;
    repeat (3) cyc();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule